// File: doc/BRIEF.md
# Access Check and Fault Status Recorder

This block sits behind a page-table walker in a memory management unit. When a walk reaches a leaf entry, the walker presents the entry's 3-bit access-control code, its modified flag, and the virtual address. It also presents the kind of access (load, store or instruction fetch) and whether the requester runs in supervisor state. One cycle later the block returns the permission set the translation cache may install, the fault type if the access is not allowed, and a choice of instruction-fault or data-fault trap.

The block holds two registers for software: a fault status word and a fault address word. A fault that nobody reads before the next one turns the status word into an overflow value before the new fault is merged in. Reading the status clears it. Two mode inputs soften faults. A no-fault mode drops user-level faults without any record. A failed access made while no-fault mode is on, or while traps are disabled, is recorded but returns full rights and raises no trap.

Top module: `access_fault_unit`

## Requirements
- R1: The access index is the 3-bit value {store, fetch, supervisor}. Access kind encoding: 0 load, 1 store, 2 fetch, 3 treated as load. A recorded fault places the index in status bits [7:5].
- R2: The fault type is 0 (none), 2 (protection) or 3 (privilege). A user access with code 6 or 7 is a privilege fault. Otherwise the access is a protection fault when the rights of its privilege level lack the needed right (read for load, write for store, execute for fetch). Rights per code for supervisor/user: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 RW/R, 6 RX/none, 7 RWX/none.
- R3: On an allowed access, rspPerm returns the R2 rights for the requester's level, encoded bit0 read, bit1 write, bit2 execute. rspFaultType gives the recorded fault type (0 when none is recorded).
- R4: Write permission is never granted when the entry's modified flag is clear.
- R5: With noFaultMode set, a faulting user access raises no trap and leaves both registers unchanged. It returns the R2 rights of its level.
- R6: A recorded fault sets status bit 1 and puts the fault type in bits [4:2]. If the status was nonzero and not being read in that cycle, it is first replaced by 1, so bit 0 marks overflow.
- R7: A recorded fault stores the virtual address in faultAddr with the low PAGE_BITS bits cleared.
- R8: If noFaultMode is set or trapsEnabled is clear, a recorded fault returns rspPerm 3'b111 and raises no trap.
- R9: Otherwise a recorded fault raises instrTrap for a fetch and dataTrap for any other kind, never both at once.
- R10: A cycle with statusRead high clears the status on the next edge unless a fault is recorded on that edge. That fault is then merged without overflow.
- R11: After reset, every output and both registers are zero.
- R12: In a cycle without reqValid, the next cycle shows rspValid, rspPerm, rspFaultType and both traps at zero, and the registers stay unchanged unless read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Leaf entry presented for checking |
| reqKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| reqSuper | input | 1 | Requester is in supervisor state |
| reqCtl | input | 3 | Access-control code of the leaf entry |
| reqModified | input | 1 | Modified flag of the leaf entry |
| reqVaddr | input | VA_W | Virtual address of the access |
| noFaultMode | input | 1 | No-fault mode enable |
| trapsEnabled | input | 1 | Processor traps enabled |
| statusRead | input | 1 | Software read of the status register |
| rspValid | output | 1 | Response valid, one cycle after reqValid |
| rspPerm | output | 3 | Granted rights: bit0 R, bit1 W, bit2 X |
| rspFaultType | output | 3 | Type of the recorded fault, 0 if none |
| instrTrap | output | 1 | Instruction access fault trap |
| dataTrap | output | 1 | Data access fault trap |
| faultStatus | output | STAT_W | Fault status register |
| faultAddr | output | VA_W | Fault address register |

## Verification
On every cycle the embedded properties check several things. The two trap outputs are never both high. A trap always comes with a valid bit in the status word. A read clears the status, and an unread fault turns into overflow. The captured address matches the page part of the request. Write rights are withheld whenever the modified flag is clear. No trap appears in the bypass modes. The bench's scenarios are needed for the rest. They show the full code-by-level rights and fault-type mapping, the exact packed status values, and the suppression of user faults without any trace. They also cover a read landing in the same cycle as a new fault, and idle cycles leaving the registers alone.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } accKind_e;

  localparam logic [2:0] FT_NONE = 3'd0;
  localparam logic [2:0] FT_PROT = 3'd2;
  localparam logic [2:0] FT_PRIV = 3'd3;

  localparam logic [2:0] PERM_ALL = 3'b111;

  // strobes from control to the register datapath
  typedef struct packed {
    logic       recordFault;
    logic       clearStatus;
    logic [2:0] accIdx;
    logic [2:0] faultType;
  } dpCtl_t;

  // rights of one privilege level for an access-control code (bit0 R, bit1 W, bit2 X)
  function automatic logic [2:0] levelRights(input logic [2:0] code, input logic sup);
    logic [2:0] r;
    case (code)
      3'd0: r = 3'b001;
      3'd1: r = 3'b011;
      3'd2: r = 3'b101;
      3'd3: r = 3'b111;
      3'd4: r = 3'b100;
      3'd5: r = sup ? 3'b011 : 3'b001;
      3'd6: r = sup ? 3'b101 : 3'b000;
      default: r = sup ? 3'b111 : 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acc_chk_decode.sv
module acc_chk_decode
  import acc_chk_pkg::*;
(
  input  logic [2:0] ctlCode,
  input  logic       isStore,
  input  logic       isFetch,
  input  logic       isSuper,
  input  logic       modified,
  output logic [2:0] faultType,
  output logic [2:0] permSet
);

  logic [2:0] rights;
  logic [2:0] needed;
  logic       privHit;

  always_comb begin
    rights  = levelRights(ctlCode, isSuper);
    needed  = isStore ? 3'b010 : (isFetch ? 3'b100 : 3'b001);
    privHit = !isSuper && (ctlCode[2:1] == 2'b11);
    if (privHit)
      faultType = FT_PRIV;
    else if ((rights & needed) == 3'b000)
      faultType = FT_PROT;
    else
      faultType = FT_NONE;
    permSet = rights & {1'b1, modified, 1'b1};
  end

endmodule

// File: rtl/acc_chk_ctrl.sv
module acc_chk_ctrl
  import acc_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqSuper,
  input  logic [2:0] reqCtl,
  input  logic       reqModified,
  input  logic       noFaultMode,
  input  logic       trapsEnabled,
  input  logic       statusRead,
  output dpCtl_t     dpCtl,
  output logic       rspValid,
  output logic [2:0] rspPerm,
  output logic [2:0] rspFaultType,
  output logic       instrTrap,
  output logic       dataTrap
);

  logic       isStore;
  logic       isFetch;
  logic [2:0] tblType;
  logic [2:0] tblPerm;
  logic       suppress;
  logic       failed;
  logic       bypass;

  assign isStore = (reqKind == KIND_STORE);
  assign isFetch = (reqKind == KIND_FETCH);

  acc_chk_decode uDecode (
    .ctlCode  (reqCtl),
    .isStore  (isStore),
    .isFetch  (isFetch),
    .isSuper  (reqSuper),
    .modified (reqModified),
    .faultType(tblType),
    .permSet  (tblPerm)
  );

  always_comb begin
    suppress = noFaultMode && !reqSuper;
    failed   = reqValid && (tblType != FT_NONE) && !suppress;
    bypass   = noFaultMode || !trapsEnabled;
    dpCtl.recordFault = failed;
    dpCtl.clearStatus = statusRead;
    dpCtl.accIdx      = {isStore, isFetch, reqSuper};
    dpCtl.faultType   = tblType;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspPerm      <= 3'b000;
      rspFaultType <= FT_NONE;
      instrTrap    <= 1'b0;
      dataTrap     <= 1'b0;
    end else begin
      rspValid     <= reqValid;
      rspPerm      <= 3'b000;
      rspFaultType <= FT_NONE;
      instrTrap    <= 1'b0;
      dataTrap     <= 1'b0;
      if (reqValid) begin
        if (failed) begin
          rspFaultType <= tblType;
          rspPerm      <= bypass ? PERM_ALL : 3'b000;
          instrTrap    <= !bypass && isFetch;
          dataTrap     <= !bypass && !isFetch;
        end else begin
          rspPerm <= tblPerm;
        end
      end
    end
  end

  // R9: one trap kind at a time
  assert_one_trap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(instrTrap && dataTrap));

  // R8: bypass modes never trap
  assert_bypass_no_trap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (noFaultMode || !trapsEnabled)) |=> (!instrTrap && !dataTrap));

  // R4: clean entry never yields write rights in normal mode
  assert_withhold_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqModified && trapsEnabled && !noFaultMode) |=> !rspPerm[1]);

  // R12: no request, no response
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !instrTrap && !dataTrap));

endmodule

// File: rtl/acc_chk_regs.sv
module acc_chk_regs
  import acc_chk_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int STAT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [VA_W-1:0]   vaddr,
  output logic [STAT_W-1:0] statusReg,
  output logic [VA_W-1:0]   addrReg
);

  localparam int IDX_LSB  = 5;
  localparam int TYPE_LSB = 2;

  logic [VA_W-1:0]   pageMask;
  logic [STAT_W-1:0] statusNext;

  for (genvar i = 0; i < VA_W; i++) begin : gMask
    assign pageMask[i] = (i >= PAGE_BITS);
  end

  always_comb begin
    statusNext = '0;
    statusNext[0] = (statusReg != '0) && !dpCtl.clearStatus;
    statusNext[1] = 1'b1;
    statusNext[TYPE_LSB +: 3] = dpCtl.faultType;
    statusNext[IDX_LSB  +: 3] = dpCtl.accIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      addrReg   <= '0;
    end else begin
      if (dpCtl.recordFault) begin
        statusReg <= statusNext;
        addrReg   <= vaddr & pageMask;
      end else if (dpCtl.clearStatus) begin
        statusReg <= '0;
      end
    end
  end

  // R10: a read with no new fault empties the status
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.clearStatus && !dpCtl.recordFault) |=> (statusReg == '0));

  // R6: unread fault followed by another gives overflow plus valid
  assert_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.recordFault && (statusReg != '0) && !dpCtl.clearStatus)
      |=> (statusReg[0] && statusReg[1]));

  // R7: captured address carries the page part of the request
  assert_addr_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.recordFault |=> (addrReg[VA_W-1:PAGE_BITS] == $past(vaddr[VA_W-1:PAGE_BITS])));

endmodule

// File: rtl/access_fault_unit.sv
module access_fault_unit
  import acc_chk_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int STAT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqSuper,
  input  logic [2:0]        reqCtl,
  input  logic              reqModified,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              noFaultMode,
  input  logic              trapsEnabled,
  input  logic              statusRead,
  output logic              rspValid,
  output logic [2:0]        rspPerm,
  output logic [2:0]        rspFaultType,
  output logic              instrTrap,
  output logic              dataTrap,
  output logic [STAT_W-1:0] faultStatus,
  output logic [VA_W-1:0]   faultAddr
);

  dpCtl_t dpCtl;

  acc_chk_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .reqSuper    (reqSuper),
    .reqCtl      (reqCtl),
    .reqModified (reqModified),
    .noFaultMode (noFaultMode),
    .trapsEnabled(trapsEnabled),
    .statusRead  (statusRead),
    .dpCtl       (dpCtl),
    .rspValid    (rspValid),
    .rspPerm     (rspPerm),
    .rspFaultType(rspFaultType),
    .instrTrap   (instrTrap),
    .dataTrap    (dataTrap)
  );

  acc_chk_regs #(
    .VA_W     (VA_W),
    .PAGE_BITS(PAGE_BITS),
    .STAT_W   (STAT_W)
  ) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .vaddr    (reqVaddr),
    .statusReg(faultStatus),
    .addrReg  (faultAddr)
  );

  // R6: any trap is backed by a valid status word
  assert_trap_logged_R6: assert property (@(posedge clk) disable iff (!rstN)
    (instrTrap || dataTrap) |-> faultStatus[1]);

endmodule

// File: tb/sim_access_fault_unit.sv
`timescale 1ns/1ps
module sim_access_fault_unit;

  localparam int VA_W = 32;
  localparam int PB   = 12;
  localparam int SW   = 32;
  localparam int NV   = 16;

  // {ctl[3], kind[2], super, modified, expPerm[3], expType[3]}
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 1'b1, 3'b001, 3'd0},
    {3'd4, 2'd0, 1'b0, 1'b1, 3'b000, 3'd2},
    {3'd6, 2'd0, 1'b0, 1'b1, 3'b000, 3'd3},
    {3'd4, 2'd0, 1'b1, 1'b1, 3'b000, 3'd2},
    {3'd7, 2'd0, 1'b1, 1'b1, 3'b111, 3'd0},
    {3'd7, 2'd0, 1'b1, 1'b0, 3'b101, 3'd0},
    {3'd5, 2'd0, 1'b0, 1'b1, 3'b001, 3'd0},
    {3'd5, 2'd1, 1'b1, 1'b1, 3'b011, 3'd0},
    {3'd6, 2'd1, 1'b1, 1'b1, 3'b000, 3'd2},
    {3'd5, 2'd1, 1'b0, 1'b1, 3'b000, 3'd2},
    {3'd2, 2'd2, 1'b0, 1'b1, 3'b101, 3'd0},
    {3'd5, 2'd2, 1'b1, 1'b1, 3'b000, 3'd2},
    {3'd6, 2'd2, 1'b1, 1'b1, 3'b101, 3'd0},
    {3'd3, 2'd1, 1'b0, 1'b0, 3'b101, 3'd0},
    {3'd1, 2'd2, 1'b0, 1'b1, 3'b000, 3'd2},
    {3'd7, 2'd1, 1'b0, 1'b1, 3'b000, 3'd3}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [1:0]      reqKind = 2'd0;
  logic            reqSuper = 1'b0;
  logic [2:0]      reqCtl = 3'd0;
  logic            reqModified = 1'b0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic            noFaultMode = 1'b0;
  logic            trapsEnabled = 1'b1;
  logic            statusRead = 1'b0;
  logic            rspValid;
  logic [2:0]      rspPerm;
  logic [2:0]      rspFaultType;
  logic            instrTrap;
  logic            dataTrap;
  logic [SW-1:0]   faultStatus;
  logic [VA_W-1:0] faultAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  access_fault_unit #(.VA_W(VA_W), .PAGE_BITS(PB), .STAT_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqSuper(reqSuper), .reqCtl(reqCtl), .reqModified(reqModified),
    .reqVaddr(reqVaddr), .noFaultMode(noFaultMode), .trapsEnabled(trapsEnabled),
    .statusRead(statusRead), .rspValid(rspValid), .rspPerm(rspPerm),
    .rspFaultType(rspFaultType), .instrTrap(instrTrap), .dataTrap(dataTrap),
    .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one request; returns at the negedge where the response is visible
  task automatic issue(input logic [2:0] ctl, input logic [1:0] kind,
                       input logic sup, input logic mdf, input logic [31:0] va);
    @(negedge clk);
    reqValid = 1'b1; reqCtl = ctl; reqKind = kind;
    reqSuper = sup; reqModified = mdf; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  function automatic logic [31:0] statWord(input logic ovf, input logic [1:0] kind,
                                           input logic sup, input logic [2:0] ft);
    logic [2:0] idx;
    idx = {kind == 2'd1, kind == 2'd2, sup};
    return {24'd0, idx, ft, 1'b1, ovf};
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "rspValid", 32'(rspValid), 0);
    chk("R11", "status", faultStatus, 0);
    chk("R11", "addr", faultAddr, 0);
    chk("R11", "traps", {30'd0, instrTrap, dataTrap}, 0);

    // table walk: R1 R2 R3 R4 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [2:0] c; logic [1:0] k; logic s; logic m; logic [2:0] ep; logic [2:0] et;
      logic [31:0] va;
      {c, k, s, m, ep, et} = VEC[i];
      va = 32'h1234_5678 + 32'(i) * 32'h0101_0ABC;
      issue(c, k, s, m, va);
      chk("R3", "valid", 32'(rspValid), 1);
      chk("R3", "perm", 32'(rspPerm), 32'(ep));
      chk("R2", "type", 32'(rspFaultType), 32'(et));
      chk("R9", "instrTrap", 32'(instrTrap), 32'((et != 0) && (k == 2'd2)));
      chk("R9", "dataTrap", 32'(dataTrap), 32'((et != 0) && (k != 2'd2)));
      if (et != 0) begin
        chk("R1", "status", faultStatus, statWord(1'b0, k, s, et));
        chk("R7", "addr", faultAddr, va & 32'hFFFF_F000);
      end else begin
        chk("R1", "status idle", faultStatus, 0);
      end
      readStatus();
      chk("R10", "cleared", faultStatus, 0);
    end

    // R6 overflow: two faults without a read
    issue(3'd4, 2'd0, 1'b0, 1'b1, 32'hAAAA_1111);
    issue(3'd7, 2'd1, 1'b0, 1'b1, 32'hBBBB_2222);
    chk("R6", "overflow status", faultStatus, 32'd143);
    chk("R7", "latest addr", faultAddr, 32'hBBBB_2000);

    // R10 read in the same cycle as a fault: merged without overflow
    @(negedge clk);
    statusRead = 1'b1;
    reqValid = 1'b1; reqCtl = 3'd4; reqKind = 2'd0; reqSuper = 1'b0;
    reqModified = 1'b1; reqVaddr = 32'hCCCC_3333;
    @(negedge clk);
    statusRead = 1'b0; reqValid = 1'b0;
    chk("R10", "read+fault", faultStatus, 32'd10);
    readStatus();
    chk("R10", "read clear", faultStatus, 0);

    // R5 no-fault user suppression
    noFaultMode = 1'b1;
    issue(3'd6, 2'd0, 1'b0, 1'b1, 32'hDDDD_4444);
    chk("R5", "perm", 32'(rspPerm), 0);
    chk("R5", "traps", {30'd0, instrTrap, dataTrap}, 0);
    chk("R5", "type", 32'(rspFaultType), 0);
    chk("R5", "status", faultStatus, 0);
    chk("R5", "addr kept", faultAddr, 32'hCCCC_3000);
    issue(3'd4, 2'd0, 1'b0, 1'b1, 32'hDDDD_5555);
    chk("R5", "user X-only perm", 32'(rspPerm), 32'b100);

    // R8 no-fault supervisor fault: recorded, full rights
    issue(3'd4, 2'd0, 1'b1, 1'b1, 32'hEEEE_6666);
    chk("R8", "nf perm", 32'(rspPerm), 32'b111);
    chk("R8", "nf traps", {30'd0, instrTrap, dataTrap}, 0);
    chk("R8", "nf status", faultStatus, 32'd42);
    chk("R8", "nf type", 32'(rspFaultType), 2);
    readStatus();
    noFaultMode = 1'b0;

    // R8 traps disabled
    trapsEnabled = 1'b0;
    issue(3'd5, 2'd1, 1'b0, 1'b1, 32'h0F0F_7777);
    chk("R8", "td perm", 32'(rspPerm), 32'b111);
    chk("R8", "td traps", {30'd0, instrTrap, dataTrap}, 0);
    chk("R8", "td status", faultStatus, 32'd138);
    chk("R7", "td addr", faultAddr, 32'h0F0F_7000);
    trapsEnabled = 1'b1;

    // R12 idle cycles leave state alone
    @(negedge clk);
    reqCtl = 3'd6; reqKind = 2'd2; reqSuper = 1'b0; reqVaddr = 32'h1111_1111;
    repeat (3) @(negedge clk);
    chk("R12", "rspValid", 32'(rspValid), 0);
    chk("R12", "perm", 32'(rspPerm), 0);
    chk("R12", "traps", {30'd0, instrTrap, dataTrap}, 0);
    chk("R12", "status kept", faultStatus, 32'd138);
    chk("R12", "addr kept", faultAddr, 32'h0F0F_7000);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule